// File: doc/BRIEF.md
# I2C Master Repeated-Start Generator

This block produces a Repeated Start condition on an open-drain I2C bus for a bus master. Software (or a neighbouring sequencer) writes a control word with the request bit set while the master is idle. The block then pulls SCL low, releases SDA, lets SCL rise, holds both lines high, and finally pulls SDA low while SCL stays high. Each timed phase is measured by a reloadable baud counter. The block never drives a line high. It only enables a pull-low on each line and watches the real line levels through a two-flop synchronizer. A slave that holds SCL low therefore stretches the sequence, because the next phase does not begin until the rising edge is actually seen.

During the sequence the block watches for two kinds of bus collision, and it refuses transmit-buffer writes and control writes. Status outputs report a Start seen on the lines, completion, a refused buffer write and a bus collision. After a normal finish SDA stays pulled low, ready for the first address bit. Byte transfer and Stop generation belong to neighbouring logic.

Top module: `rsg_top`

## Requirements
- R1: After reset both pull enables are 0, and `ctrl_q`, `irq`, `start_seen`, `wcol` and `bus_coll` are all 0.
- R2: The request is bit 0 of `ctrl_wdata`, and it is accepted only when `ctrl_q[0]` is 0 and `busy_other` is 0. A request written while `busy_other` is 1 leaves `ctrl_q[0]` at 0 and does not pull SCL. A control write while idle stores bits 4:1 as written.
- R3: When the request is accepted, `scl_pull` goes to 1 and `sda_pull` goes to 0. After SCL is sampled low, the counter loads `max(reload[5:0],2)` = N1. SCL is released once the counter times out and SDA is sampled high. With the 2-flop synchronizer, SCL is low for N1+4 cycles, counted from the accepting edge.
- R4: The both-high phase starts only once SCL is sampled high, so a slave holding SCL low stretches the sequence. The counter then loads `max(reload,2)` = N2. SCL and SDA stay high for N2+4 cycles, counted from the moment the SCL line actually rises.
- R5: Next, SDA is pulled low with SCL released for N2+1 cycles. At that point `ctrl_q[0]` clears and `irq` rises in the same cycle. `sda_pull` then stays 1 and `scl_pull` stays 0 while idle.
- R6: `start_seen` clears when a request is accepted. It sets once SDA is sampled falling while SCL is sampled high, so it is 0 during the both-high phase and 1 at completion.
- R7: A `buf_wr` while `ctrl_q[0]` is 1 sets `wcol` and leaves `buf_q` unchanged. A `buf_wr` while idle loads `buf_q` and clears `wcol`.
- R8: A control write while `ctrl_q[0]` is 1 changes none of `ctrl_q[4:1]`.
- R9: If SDA is sampled low when SCL is first sampled high after its release, the block raises `bus_coll` and releases both lines. It also clears `ctrl_q[0]` and leaves `irq` at 0.
- R10: If SCL is sampled low during the both-high phase, or during the SDA-low phase before SDA is sampled low, the block behaves as in R9.
- R11: A counter load below 2 is raised to 2, so a reload of 0 gives phase lengths of 6, 6 and 3 cycles.
- R12: `scl_pull` and `sda_pull` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 5 | Control write data; bit 0 is the repeated-start request |
| ctrl_q | output | 5 | Control register; bit 0 reads 1 while the sequence runs |
| busy_other | input | 1 | Another bus event is in progress |
| reload | input | 7 | Baud counter reload value |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| buf_q | output | 8 | Transmit buffer contents |
| scl_in | input | 1 | Actual SCL line level |
| sda_in | input | 1 | Actual SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| start_seen | output | 1 | Start condition detected on the lines |
| irq | output | 1 | Sequence completed |
| wcol | output | 1 | Buffer write refused |
| bus_coll | output | 1 | Bus collision during the sequence |

## Verification
Several rules hold on every cycle, and the assertions check them there. The two pull enables are never active together. Completion and request clearing coincide, and a collision leaves both lines free with no completion flag. Writes to the buffer or to the control bits during a sequence change nothing. A request made while another event is running is refused. Only the bench scenarios can show the phase lengths for several reload values, including the clamp to 2. They also show clock stretching by a slave holding SCL, the exact moment the Start is detected, and which line misbehaviour triggers each collision.

// File: rtl/rsg_pkg.sv
// Shared types for the repeated-start generator.
// Assumes nothing beyond a single clock domain for the logic that imports it.
package rsg_pkg;

    // Phase of the repeated-start sequence
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SCL_DOWN = 3'd1,
        ST_SDA_UP   = 3'd2,
        ST_SCL_UP   = 3'd3,
        ST_BOTH_HI  = 3'd4,
        ST_SDA_DOWN = 3'd5
    } rsg_state_e;

endpackage

// File: rtl/rsg_sync.sv
// Multi-flop synchronizer for the sampled bus line levels.
// Assumes the idle (reset) level of every line is high.
module rsg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the line levels
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift the line levels through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/rsg_baud.sv
// Reloadable down-counter timing one baud period.
// A load of N gives N+1 cycles up to the timeout. Loads below MIN_LOAD are raised.
// Assumes the caller looks at tout only in timed phases.
module rsg_baud #(
    parameter int W        = 7,
    parameter int MIN_LOAD = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         tout
);
    localparam logic [W-1:0] MINV = W'(MIN_LOAD);

    logic [W-1:0] cnt;

    // Load with clamping, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= (load_val < MINV) ? MINV : load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign tout = (cnt == '0);
endmodule

// File: rtl/rsg_top.sv
// I2C master repeated-start generator.
// Sequences SCL low, SDA release, SCL rise, both high, and SDA low. Each phase
// waits for the synchronized line level and is then timed by the baud counter.
// Checks for two bus collisions and refuses buffer and control writes while it runs.
// Assumes external pull-ups and an open-drain bus; outputs are pull-low enables.
module rsg_top
    import rsg_pkg::*;
#(
    parameter int CTRL_W      = 5,
    parameter int REQ_BIT     = 0,
    parameter int BRG_W       = 7,
    parameter int FIRST_W     = 6,
    parameter int MIN_LOAD    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              busy_other,
    input  logic [BRG_W-1:0]  reload,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic [DATA_W-1:0] buf_q,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              start_seen,
    output logic              irq,
    output logic              wcol,
    output logic              bus_coll
);
    localparam int PAD_W = BRG_W - FIRST_W;

    rsg_state_e        state, state_n;
    logic              scl_s, sda_s, sda_prev;
    logic              ld;
    logic [BRG_W-1:0]  ld_val;
    logic              tout;
    logic              scl_n, sda_n;
    logic              fin, coll, accept, idle;
    logic [1:0]        sync_q;

    rsg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    rsg_baud #(.W(BRG_W), .MIN_LOAD(MIN_LOAD)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .tout     (tout)
    );

    assign idle   = (state == ST_IDLE);
    assign accept = idle && ctrl_wr && ctrl_wdata[REQ_BIT] && !busy_other;

    // Next phase, counter loads and line pulls for the sequence
    always_comb begin
        state_n = state;
        ld      = 1'b0;
        ld_val  = '0;
        scl_n   = scl_pull;
        sda_n   = sda_pull;
        fin     = 1'b0;
        coll    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_n = ST_SCL_DOWN;
                    scl_n   = 1'b1;
                    sda_n   = 1'b0;
                end
            end
            ST_SCL_DOWN: begin
                if (!scl_s) begin
                    ld      = 1'b1;
                    ld_val  = {{PAD_W{1'b0}}, reload[FIRST_W-1:0]};
                    state_n = ST_SDA_UP;
                end
            end
            ST_SDA_UP: begin
                if (tout && sda_s) begin
                    scl_n   = 1'b0;
                    state_n = ST_SCL_UP;
                end
            end
            ST_SCL_UP: begin
                if (scl_s) begin
                    if (!sda_s) begin
                        coll = 1'b1;
                    end else begin
                        ld      = 1'b1;
                        ld_val  = reload;
                        state_n = ST_BOTH_HI;
                    end
                end
            end
            ST_BOTH_HI: begin
                if (!scl_s) begin
                    coll = 1'b1;
                end else if (tout) begin
                    sda_n   = 1'b1;
                    ld      = 1'b1;
                    ld_val  = reload;
                    state_n = ST_SDA_DOWN;
                end
            end
            ST_SDA_DOWN: begin
                if (!scl_s && sda_s) begin
                    coll = 1'b1;
                end else if (tout) begin
                    fin     = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (coll) begin
            state_n = ST_IDLE;
            scl_n   = 1'b0;
            sda_n   = 1'b0;
        end
    end

    // Sequence state and registered line pulls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            state    <= state_n;
            scl_pull <= scl_n;
            sda_pull <= sda_n;
        end
    end

    // Control register: written only while idle; the request bit self-clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr && idle) begin
            ctrl_q          <= ctrl_wdata;
            ctrl_q[REQ_BIT] <= accept;
        end else if (fin || coll) begin
            ctrl_q[REQ_BIT] <= 1'b0;
        end
    end

    // Transmit buffer with write-collision flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            wcol  <= 1'b0;
        end else if (buf_wr) begin
            if (idle) begin
                buf_q <= buf_wdata;
                wcol  <= 1'b0;
            end else begin
                wcol  <= 1'b1;
            end
        end
    end

    // Completion, collision and start-detect status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            bus_coll   <= 1'b0;
            start_seen <= 1'b0;
            sda_prev   <= 1'b1;
        end else begin
            sda_prev <= sda_s;
            if (accept) begin
                irq        <= 1'b0;
                bus_coll   <= 1'b0;
                start_seen <= 1'b0;
            end else begin
                if (fin)                            irq        <= 1'b1;
                if (coll)                           bus_coll   <= 1'b1;
                if (scl_s && sda_prev && !sda_s)    start_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsg_chk.sv
// Cycle-level property checker for rsg_top, attached with bind.
// Assumes bit 0 of the control register is the request bit.
module rsg_chk #(
    parameter int CTRL_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic              busy_other,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              buf_wr,
    input logic [DATA_W-1:0] buf_q,
    input logic              scl_pull,
    input logic              sda_pull,
    input logic              irq,
    input logic              wcol,
    input logic              bus_coll
);
    // R12
    never_both_pulled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_pull && sda_pull));

    // R3
    seq_opens_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[0]) |-> (scl_pull && !sda_pull));

    // R5
    irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(ctrl_q[0]));

    // R9
    coll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_coll) |-> (!scl_pull && !sda_pull && !irq && !ctrl_q[0]));

    // R7
    wcol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && ctrl_q[0]) |=> (wcol && $stable(buf_q)));

    // R8
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_q[0]) |=> (ctrl_q[CTRL_W-1:1] == $past(ctrl_q[CTRL_W-1:1])));

    // R2
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy_other && !ctrl_q[0]) |=> !ctrl_q[0]);
endmodule

bind rsg_top rsg_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .busy_other (busy_other),
    .ctrl_q     (ctrl_q),
    .buf_wr     (buf_wr),
    .buf_q      (buf_q),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull),
    .irq        (irq),
    .wcol       (wcol),
    .bus_coll   (bus_coll)
);

// File: tb/rsg_top_test.sv
// Scoreboard bench for rsg_top: the driver pushes expected phase lengths,
// and the monitor measures the lines at each negedge and compares them when the request drops.
module rsg_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [4:0] ctrl_q;
    logic       busy_other = 1'b0;
    logic [6:0] reload = '0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_q;
    logic       scl_pull, sda_pull, start_seen, irq, wcol, bus_coll;
    logic       scl_hold = 1'b0;
    logic       sda_hold = 1'b0;
    logic       scl_line, sda_line;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    coll;
        int    lo;
        int    hh;
        int    sl;
        string tag;
    } exp_t;
    exp_t sb[$];

    assign scl_line = !scl_pull && !scl_hold;
    assign sda_line = !sda_pull && !sda_hold;

    always #2 clk = ~clk;

    rsg_top uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .busy_other(busy_other), .reload(reload),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
        .scl_in(scl_line), .sda_in(sda_line), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .start_seen(start_seen), .irq(irq),
        .wcol(wcol), .bus_coll(bus_coll)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: per-phase line measurement, compared at the end of each sequence
    int  lo_n = 0, hh_n = 0, sl_n = 0;
    bit  early_start = 1'b0;
    bit  prev_req = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ctrl_q[0]) begin
                if (!scl_line)      lo_n++;
                else if (sda_line) begin
                    hh_n++;
                    if (start_seen) early_start = 1'b1;
                end else            sl_n++;
            end else if (prev_req) begin
                if (sb.size() == 0) begin
                    check("R5 unexpected sequence end", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.coll) begin
                        check({e.tag, " bus_coll"}, int'(bus_coll), 1);
                        check({e.tag, " irq"}, int'(irq), 0);
                        check({e.tag, " lines released"}, int'(scl_pull | sda_pull), 0);
                    end else begin
                        if (e.lo >= 0) check({e.tag, " R3 scl low length"}, lo_n, e.lo);
                        check({e.tag, " R4 both-high length"}, hh_n, e.hh);
                        check({e.tag, " R5 sda-low length"}, sl_n, e.sl);
                        check({e.tag, " R5 irq"}, int'(irq), 1);
                        check({e.tag, " R5 sda held"}, int'(sda_pull & !scl_pull), 1);
                        check({e.tag, " R6 start_seen at end"}, int'(start_seen), 1);
                        check({e.tag, " R6 start_seen not early"}, int'(early_start), 0);
                        check({e.tag, " no bus_coll"}, int'(bus_coll), 0);
                    end
                end
                lo_n = 0; hh_n = 0; sl_n = 0; early_start = 1'b0;
            end
            prev_req = ctrl_q[0];
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ctrl_write(input logic [4:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1;
        tick(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic buf_write(input logic [7:0] v);
        buf_wdata = v; buf_wr = 1'b1;
        tick(1);
        buf_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (ctrl_q[0]) tick(1);
        tick(2);
    endtask

    function automatic int clamp(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    // Driver: one normal sequence with expectations from R3, R4, R5, R11
    task automatic normal_seq(input logic [6:0] rl, input string tag);
        exp_t e;
        e.coll = 0;
        e.lo = clamp(int'(rl[5:0])) + 4;
        e.hh = clamp(int'(rl)) + 4;
        e.sl = clamp(int'(rl)) + 1;
        e.tag = tag;
        sb.push_back(e);
        reload = rl;
        ctrl_write(5'b00001);
        wait_idle();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1
        check("R1 scl_pull", int'(scl_pull), 0);
        check("R1 sda_pull", int'(sda_pull), 0);
        check("R1 ctrl_q", int'(ctrl_q), 0);
        check("R1 flags", int'({start_seen, irq, wcol, bus_coll}), 0);

        // R2: request refused while another event runs
        busy_other = 1'b1;
        ctrl_write(5'b00011);
        tick(4);
        busy_other = 1'b0;
        check("R2 request refused", int'(ctrl_q[0]), 0);
        check("R2 no scl pull", int'(scl_pull), 0);
        check("R2 idle write stores bits", int'(ctrl_q), 5'b00010);

        // R7: idle buffer write
        buf_write(8'h5A);
        check("R7 idle buffer load", int'(buf_q), 8'h5A);

        // R3 R4 R5 with several reload values; R11 clamp
        normal_seq(7'h03, "rl03");
        normal_seq(7'h45, "rl45");
        normal_seq(7'h00, "R11 rl00");
        normal_seq(7'h7F, "rl7F");

        // R7 R8: writes during a sequence
        begin
            exp_t e;
            e.coll = 0; e.lo = 9; e.hh = 73; e.sl = 70; e.tag = "R7R8 seq";
            sb.push_back(e);
            reload = 7'h45;
            ctrl_write(5'b00001);
            tick(3);
            buf_write(8'hC3);
            ctrl_write(5'b10100);
            tick(1);
            check("R7 wcol set", int'(wcol), 1);
            check("R7 buffer unchanged", int'(buf_q), 8'h5A);
            check("R8 ctrl bits unchanged", int'(ctrl_q[4:1]), 0);
            wait_idle();
            check("R8 ctrl after sequence", int'(ctrl_q), 0);
            buf_write(8'h3C);
            check("R7 idle write after", int'(buf_q), 8'h3C);
            check("R7 wcol cleared", int'(wcol), 0);
        end

        // R4: clock stretching by a slave holding SCL
        begin
            exp_t e;
            e.coll = 0; e.lo = -1; e.hh = 14; e.sl = 11; e.tag = "R4 stretch";
            sb.push_back(e);
            reload = 7'h0A;
            scl_hold = 1'b1;
            ctrl_write(5'b00001);
            while (scl_pull) tick(1);
            tick(9);
            check("R4 waits for scl high", int'(sda_pull), 0);
            scl_hold = 1'b0;
            wait_idle();
        end

        // R9: SDA low when SCL rises
        begin
            exp_t e;
            e.coll = 1; e.lo = 0; e.hh = 0; e.sl = 0; e.tag = "R9 sda low at rise";
            sb.push_back(e);
            reload = 7'h05;
            ctrl_write(5'b00001);
            while (scl_pull) tick(1);
            sda_hold = 1'b1;
            wait_idle();
            sda_hold = 1'b0;
            tick(2);
        end

        // R10: SCL pulled low during the both-high phase
        begin
            exp_t e;
            e.coll = 1; e.lo = 0; e.hh = 0; e.sl = 0; e.tag = "R10 scl low early";
            sb.push_back(e);
            reload = 7'h0A;
            ctrl_write(5'b00001);
            while (scl_pull) tick(1);
            tick(3);
            scl_hold = 1'b1;
            wait_idle();
            scl_hold = 1'b0;
            tick(2);
        end

        // R6 R3: a normal sequence after a collision clears the flags
        normal_seq(7'h04, "R6 after coll");

        check("R5 scoreboard drained", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule